// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block sits between a simple request/response host port and an asynchronous EDO DRAM. It accepts one request at a time. Each request is a read or a write to a row and a column, and carries a hint that says whether the row should stay open afterwards. The block drives the row-address strobe, column-address strobe, write enable, output enable and the multiplexed address bus. Every strobe width and gap is a parameter counted in clock cycles. A read returns its data with a one-cycle valid pulse.

The first access to a closed page strobes the row with RAS# falling, waits the RAS-to-CAS delay, then strobes the column with CAS# falling. While the page stays open, requests to the same row only cycle CAS# with a fresh column address, and RAS# stays low. A request for another row, a request carrying a release hint, or a refresh grant drives RAS# high. RAS# then stays high for the precharge count before any new row is strobed.

The block never drives DQ while the memory may still be driving it. The memory starts driving when CAS# falls with WE# high, which leaves it driving after a read (extended data out). It stops driving only after WE# has been low for a set time, or after both strobes have been high for a set time. Before an early write, the block pulls WE# low and waits for that float delay before it puts write data on DQ.

Top module: `edo_page_seq`

## Requirements
- R1: After reset, ras_n, cas_n, we_n and oe_n are all 1, dq_oe and rd_valid are 0, and req_ready is 1.
- R2: On a closed page, the row is placed on dram_addr and RAS# falls. CAS# then falls with the column on dram_addr no earlier than T_RCD cycles after RAS# fell.
- R3: Requests to the open row cause no new RAS# fall. Each one is served by a CAS# fall, with its column on dram_addr and RAS# low.
- R4: RAS# stays high for at least T_RP cycles before every RAS# fall, including when a request to a different row closes the open page.
- R5: An access with req_hold_page = 0 closes the page afterwards. RAS# returns to 1, and the next access to that same row strobes the row again.
- R6: Each CAS# low pulse lasts exactly T_CAS cycles. Between two CAS# falls within one open page, CAS# stays high for at least T_CP cycles.
- R7: Read data is sampled exactly T_SAMPLE cycles after CAS# falls. It is returned on rd_data with rd_valid high for exactly one cycle, in request order.
- R8: For a write, WE# is low and dq_oe is high with the write data on dram_dq_out when CAS# falls. dq_oe is 1 only while WE# is low.
- R9: The memory drives DQ from a CAS# fall with WE# high (and oe_n low). It stops once WE# has been low for T_WHZ consecutive cycles, or once both strobes have been high for T_OFF consecutive cycles. dq_oe is never 1 while the memory drives DQ.
- R10: req_ready is 0 from the cycle after an accepted request until the access completes, and 0 whenever ref_grant is 1. A grant while a page is open drives RAS# high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| req_hold_page | input | 1 | 1 = keep the row open after this access |
| ref_grant | input | 1 | Memory handed to refresh; stop accepting and close the page |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row-address strobe, active low |
| dram_cas_n | output | 1 | Column-address strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data toward the memory |
| dram_dq_oe | output | 1 | Controller drives DQ |
| dram_dq_in | input | DATA_W | Data from the memory |

## Verification
A burst of same-row writes followed by same-row reads shows that the page stays open: it must produce one RAS# fall per burst while returning the right data. Alternating rows and explicit release hints separate the page-hit path from the close-and-reopen path and its precharge gap. A write issued straight after a read in the same open page is the case that shows the WE# turnaround waits for the memory to float DQ. A pseudo-random mix of reads, writes and rows then checks ordering and data against a reference memory, and a refresh grant with a page open checks the close and the withheld ready.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,    // waiting; page may be open
    S_ROWSET,  // row address set up, RAS# falls at the end
    S_RCD,     // RAS-to-CAS wait
    S_COL,     // column address set up
    S_WSET,    // write data set up before CAS# falls
    S_CASL,    // CAS# low
    S_CP,      // CAS# precharge
    S_PRE      // RAS# precharge
  } seq_state_t;

  function automatic int f_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..lim
  function automatic int f_cnt_w(input int lim);
    int w;
    w = 1;
    while ((1 << w) <= lim) w++;
    return w;
  endfunction

  // a cycle count has reached its programmed limit
  function automatic logic f_reached(input int cnt, input int lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/edo_page_tracker.sv
module edo_page_tracker #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_ev,
  input  logic             close_ev,
  input  logic [ROW_W-1:0] open_row_in,
  input  logic [ROW_W-1:0] probe_row,
  output logic             page_open,
  output logic             page_hit
);
  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_open  <= 1'b0;
      open_row_q <= '0;
    end else if (close_ev) begin
      page_open <= 1'b0;
    end else if (open_ev) begin
      page_open  <= 1'b1;
      open_row_q <= open_row_in;
    end
  end

  assign page_hit = page_open && (open_row_q == probe_row);
endmodule

// File: rtl/edo_dq_guard.sv
module edo_dq_guard #(
  parameter int T_WHZ = 1,
  parameter int T_OFF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic dev_drive
);
  import edo_seq_pkg::*;

  localparam int GW = f_cnt_w(f_max(T_WHZ, T_OFF));

  logic          prev_cas;
  logic [GW-1:0] whz_cnt, whz_nx;
  logic [GW-1:0] off_cnt, off_nx;
  logic          read_edge;

  assign read_edge = prev_cas && !cas_n && we_n;

  always_comb begin
    if (we_n)                       whz_nx = '0;
    else if (whz_cnt == GW'(T_WHZ)) whz_nx = whz_cnt;
    else                            whz_nx = whz_cnt + 1'b1;
    if (!(ras_n && cas_n))          off_nx = '0;
    else if (off_cnt == GW'(T_OFF)) off_nx = off_cnt;
    else                            off_nx = off_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_cas  <= 1'b1;
      whz_cnt   <= '0;
      off_cnt   <= '0;
      dev_drive <= 1'b0;
    end else begin
      prev_cas <= cas_n;
      whz_cnt  <= whz_nx;
      off_cnt  <= off_nx;
      if (read_edge)
        dev_drive <= 1'b1;
      else if (f_reached(int'(whz_nx), T_WHZ) || f_reached(int'(off_nx), T_OFF))
        dev_drive <= 1'b0;
    end
  end
endmodule

// File: rtl/edo_rd_capture.sv
module edo_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sample_en;
      if (sample_en) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq #(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 8,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 3,
  parameter int T_CP     = 1,
  parameter int T_RP     = 3,
  parameter int T_SAMPLE = 2,
  parameter int T_WHZ    = 1,
  parameter int T_OFF    = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [ROW_W-1:0]                      req_row,
  input  logic [COL_W-1:0]                      req_col,
  input  logic [DATA_W-1:0]                     req_wdata,
  input  logic                                  req_hold_page,
  input  logic                                  ref_grant,
  output logic                                  rd_valid,
  output logic [DATA_W-1:0]                     rd_data,
  output logic                                  dram_ras_n,
  output logic                                  dram_cas_n,
  output logic                                  dram_we_n,
  output logic                                  dram_oe_n,
  output logic [edo_seq_pkg::f_max(ROW_W,COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]                     dram_dq_out,
  output logic                                  dram_dq_oe,
  input  logic [DATA_W-1:0]                     dram_dq_in
);
  import edo_seq_pkg::*;

  localparam int ADDR_W = f_max(ROW_W, COL_W);
  localparam int T_MAX  = f_max(f_max(T_RCD, T_CAS), f_max(T_CP, T_RP));
  localparam int CNT_W  = f_cnt_w(T_MAX);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              cur_write, cur_hold, pend;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [DATA_W-1:0] cur_wdata;

  // named internal events
  logic accept, page_open, page_hit, dev_drive, bus_free, sample_en;
  logic open_ev, close_ev;

  assign req_ready = (state == S_IDLE) && !ref_grant;
  assign accept    = req_valid && req_ready;
  assign bus_free  = !dev_drive;
  assign open_ev   = (state == S_ROWSET);
  assign close_ev  = (state == S_PRE);
  assign sample_en = (state == S_CASL) && !cur_write && (int'(cnt) == T_SAMPLE);

  edo_page_tracker #(.ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_n), .open_ev(open_ev), .close_ev(close_ev),
    .open_row_in(cur_row), .probe_row(req_row),
    .page_open(page_open), .page_hit(page_hit)
  );

  edo_dq_guard #(.T_WHZ(T_WHZ), .T_OFF(T_OFF)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .dev_drive(dev_drive)
  );

  edo_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .dq_in(dram_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      cur_write   <= 1'b0;
      cur_hold    <= 1'b0;
      cur_row     <= '0;
      cur_col     <= '0;
      cur_wdata   <= '0;
      pend        <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            cur_write <= req_write;
            cur_hold  <= req_hold_page;
            cur_row   <= req_row;
            cur_col   <= req_col;
            cur_wdata <= req_wdata;
            if (page_hit) begin
              dram_addr <= ADDR_W'(req_col);
              dram_we_n <= ~req_write;
              dram_oe_n <= req_write;
              state     <= S_COL;
            end else if (page_open) begin
              dram_ras_n <= 1'b1;
              dram_oe_n  <= 1'b1;
              cnt        <= CNT_W'(1);
              pend       <= 1'b1;
              state      <= S_PRE;
            end else begin
              dram_addr <= ADDR_W'(req_row);
              state     <= S_ROWSET;
            end
          end else if (ref_grant && page_open) begin
            dram_ras_n <= 1'b1;
            dram_oe_n  <= 1'b1;
            cnt        <= CNT_W'(1);
            pend       <= 1'b0;
            state      <= S_PRE;
          end
        end
        S_ROWSET: begin
          dram_ras_n <= 1'b0;
          cnt        <= CNT_W'(1);
          state      <= S_RCD;
        end
        S_RCD: begin
          if (f_reached(int'(cnt), T_RCD - 1)) begin
            dram_addr <= ADDR_W'(cur_col);
            dram_we_n <= ~cur_write;
            dram_oe_n <= cur_write;
            state     <= S_COL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_COL: begin
          if (!cur_write) begin
            dram_cas_n <= 1'b0;
            cnt        <= CNT_W'(1);
            state      <= S_CASL;
          end else if (bus_free) begin
            dram_dq_oe  <= 1'b1;
            dram_dq_out <= cur_wdata;
            state       <= S_WSET;
          end
        end
        S_WSET: begin
          dram_cas_n <= 1'b0;
          cnt        <= CNT_W'(1);
          state      <= S_CASL;
        end
        S_CASL: begin
          if (f_reached(int'(cnt), T_CAS)) begin
            dram_cas_n <= 1'b1;
            dram_dq_oe <= 1'b0;
            dram_we_n  <= 1'b1;
            cnt        <= CNT_W'(1);
            state      <= S_CP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CP: begin
          if (f_reached(int'(cnt), T_CP)) begin
            if (cur_hold) begin
              state <= S_IDLE;
            end else begin
              dram_ras_n <= 1'b1;
              dram_oe_n  <= 1'b1;
              cnt        <= CNT_W'(1);
              pend       <= 1'b0;
              state      <= S_PRE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PRE: begin
          if (f_reached(int'(cnt), T_RP)) begin
            if (pend) begin
              dram_addr <= ADDR_W'(cur_row);
              pend      <= 1'b0;
              state     <= S_ROWSET;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edo_seq_checks.sv
module edo_seq_checks #(
  parameter int T_RP  = 3,
  parameter int T_CAS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dq_oe,
  input logic rd_valid,
  input logic req_valid,
  input logic req_ready,
  input logic dev_drive
);
  logic [7:0] ras_hi_cnt, cas_lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_hi_cnt <= 8'(T_RP);
      cas_lo_cnt <= '0;
    end else begin
      if (!ras_n)                ras_hi_cnt <= '0;
      else if (ras_hi_cnt != '1) ras_hi_cnt <= ras_hi_cnt + 1'b1;
      if (cas_n)                 cas_lo_cnt <= '0;
      else if (cas_lo_cnt != '1) cas_lo_cnt <= cas_lo_cnt + 1'b1;
    end
  end

  assert_cas_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !ras_n);

  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (int'(ras_hi_cnt) >= T_RP));

  assert_cas_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (int'(cas_lo_cnt) >= T_CAS));

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_drive_with_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !dev_drive);

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind edo_page_seq edo_seq_checks #(.T_RP(T_RP), .T_CAS(T_CAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .dq_oe(dram_dq_oe), .rd_valid(rd_valid),
  .req_valid(req_valid), .req_ready(req_ready), .dev_drive(dev_drive)
);

// File: tb/edo_page_seq_bench.sv
module edo_page_seq_bench;
  localparam int ROW_W = 12, COL_W = 10, DATA_W = 8;
  localparam int T_RCD = 2, T_CAS = 3, T_CP = 1, T_RP = 3;
  localparam int T_SAMPLE = 2, T_WHZ = 1, T_OFF = 2;
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_hold_page = 1'b0, ref_grant = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_out, dq_in;
  logic [ADDR_W-1:0] addr;

  always #2 clk = ~clk;

  edo_page_seq u_edo_page_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_hold_page(req_hold_page), .ref_grant(ref_grant),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] exp_q [$];

  task automatic fail(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual %0h expected %0h", req, act, exp);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) fail(req, act, exp);
  endtask

  // memory model and timing monitor, all on the falling edge
  int cyc = 0, ras_falls = 0;
  int ras_hi_run = T_RP, cas_hi_run = 0, cas_lo_run = 0, wl = 0, hl = 0;
  int ras_fall_cyc = 0, cas_fall_cyc = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, first_cas = 1'b0, drv = 1'b0;
  logic [3:0] m_row = '0, m_col = '0;
  logic [7:0] dout = '0;

  assign dq_in = (drv && !oe_n) ? dout : 8'h00;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_ras = 1'b1; prev_cas = 1'b1; drv = 1'b0; wl = 0; hl = 0;
      ras_hi_run = T_RP; cas_hi_run = 0; cas_lo_run = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        checks++;
        if (ras_hi_run < T_RP) fail("R4 precharge", ras_hi_run, T_RP);
        m_row = addr[3:0];
        ras_falls++;
        ras_fall_cyc = cyc;
        first_cas = 1'b1;
      end
      if (prev_cas && !cas_n) begin
        m_col = addr[3:0];
        chk("R3 ras low at cas fall", int'(ras_n), 0);
        if (first_cas) begin
          checks++;
          if (cyc - ras_fall_cyc < T_RCD) fail("R2 ras-to-cas", cyc - ras_fall_cyc, T_RCD);
          first_cas = 1'b0;
        end else begin
          checks++;
          if (cas_hi_run < T_CP) fail("R6 cas precharge", cas_hi_run, T_CP);
        end
        if (!we_n) begin
          chk("R8 dq driven at write cas", int'(dq_oe), 1);
          mem[{m_row, m_col}] = dq_out;
        end else begin
          drv = 1'b1;
          dout = mem[{m_row, m_col}];
        end
        cas_fall_cyc = cyc;
      end
      if (!prev_cas && cas_n) chk("R6 cas width", cas_lo_run, T_CAS);
      // float rules of the memory
      wl = we_n ? 0 : wl + 1;
      hl = (ras_n && cas_n) ? hl + 1 : 0;
      if (!(prev_cas && !cas_n && we_n) && (wl >= T_WHZ || hl >= T_OFF)) drv = 1'b0;
      if (dq_oe) begin
        checks++;
        if (drv) fail("R9 dq contention", 1, 0);
      end
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      cas_hi_run = cas_n ? cas_hi_run + 1 : 0;
      cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
      prev_ras = ras_n;
      prev_cas = cas_n;
      // scoreboard monitor
      if (rd_valid) begin
        chk("R7 sample point", cyc - cas_fall_cyc, T_SAMPLE);
        checks++;
        if (exp_q.size() == 0) fail("R7 unexpected read", int'(rd_data), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (rd_data != e) fail("R7 read data", int'(rd_data), int'(e));
        end
      end
    end
  end

  task automatic do_req(input logic wr, input logic [3:0] row, input logic [3:0] col,
                        input logic [7:0] d, input logic hold);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_row = ROW_W'(row); req_col = COL_W'(col);
    req_wdata = d; req_hold_page = hold;
    if (wr) ref_mem[{row, col}] = d;
    else exp_q.push_back(ref_mem[{row, col}]);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy after accept", int'(req_ready), 0);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fail("watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] lf;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    settle(3);
    // R1 reset state
    chk("R1 ras_n", int'(ras_n), 1); chk("R1 cas_n", int'(cas_n), 1);
    chk("R1 we_n", int'(we_n), 1);   chk("R1 oe_n", int'(oe_n), 1);
    chk("R1 dq_oe", int'(dq_oe), 0); chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 ready", int'(req_ready), 1);
    rst_n = 1'b1;
    settle(2);

    // same-row write burst: one row strobe (R3), closed after (R5)
    base = ras_falls;
    do_req(1'b1, 4'd1, 4'd0, 8'hA1, 1'b1);
    do_req(1'b1, 4'd1, 4'd1, 8'hB2, 1'b1);
    do_req(1'b1, 4'd1, 4'd2, 8'hC3, 1'b0);
    settle(12);
    chk("R3 one row strobe for write burst", ras_falls - base, 1);
    chk("R5 page closed after release", int'(ras_n), 1);

    // same-row read burst reopens the row (R5) and stays open (R3)
    base = ras_falls;
    do_req(1'b0, 4'd1, 4'd0, 8'h00, 1'b1);
    do_req(1'b0, 4'd1, 4'd1, 8'h00, 1'b1);
    do_req(1'b0, 4'd1, 4'd2, 8'h00, 1'b1);
    settle(12);
    chk("R5 reopen strobes row", ras_falls - base, 1);
    chk("R3 page kept open", int'(ras_n), 0);

    // row miss with page open (R4), then read-to-write turnaround (R9, R8)
    base = ras_falls;
    do_req(1'b0, 4'd2, 4'd5, 8'h00, 1'b1);
    do_req(1'b0, 4'd3, 4'd7, 8'h00, 1'b1);
    do_req(1'b1, 4'd3, 4'd7, 8'h96, 1'b1);
    do_req(1'b0, 4'd3, 4'd7, 8'h00, 1'b1);
    settle(12);
    chk("R4 two row changes", ras_falls - base, 2);

    // refresh grant with page open (R10)
    ref_grant = 1'b1;
    settle(1);
    chk("R10 ready low under grant", int'(req_ready), 0);
    settle(8);
    chk("R10 grant closes page", int'(ras_n), 1);
    chk("R10 ready still low", int'(req_ready), 0);
    ref_grant = 1'b0;
    settle(2);
    chk("R10 ready back", int'(req_ready), 1);

    // pseudo-random mix of rows, reads and writes
    lf = 8'h1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      do_req(lf[0], {2'b00, lf[2:1]}, lf[6:3], lf ^ 8'h3C, (i % 7) != 6);
    end
    do_req(1'b0, 4'd0, 4'd0, 8'h00, 1'b0);
    settle(20);
    chk("R7 all reads returned", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule